// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a register of parameterizable width whose contents, at each rising clock edge, are held, moved one place toward the least significant end, moved one place toward the most significant end, or replaced by a parallel word. A two-bit mode input selects the operation. Each stage takes its next value from a four-way selection steered by that mode. Shifts toward the least significant end take their fill bit from one serial input. Shifts toward the most significant end take theirs from a second, independent serial input.

The full register is always visible on a parallel output. The bit leaving at each end is offered on its own port, so another register can be fed serially. A build-time option connects each end's outgoing bit back to the opposite end. The register then rotates instead of shifting, and the serial inputs have no effect. A synchronous active-high clear sets every stage to zero and takes priority over the mode.

Top module: `univ_shreg`

## Requirements
- R1: When `clr` is 1 at a rising edge, every bit of `q` becomes 0 after that edge, whatever `mode`, `par_in` and the serial inputs hold.
- R2: With `clr` 0 and `mode` = 2'b00, `q` keeps its value across the edge; changes on `par_in`, `ser_in_r` and `ser_in_l` have no effect.
- R3: With `clr` 0 and `mode` = 2'b01, `q` becomes `{ser_in_r, q[WIDTH-1:1]}`: bit i takes bit i+1, and the fill bit enters bit WIDTH-1.
- R4: With `clr` 0 and `mode` = 2'b10, `q` becomes `{q[WIDTH-2:0], ser_in_l}`: bit i takes bit i-1, and the fill bit enters bit 0.
- R5: With `clr` 0 and `mode` = 2'b11, all bits of `par_in` are copied into `q` together at the edge.
- R6: `ser_out_r` always equals `q[0]` and `ser_out_l` always equals `q[WIDTH-1]`.
- R7: With `ROTATE` = 1, mode 2'b01 moves the old `q[0]` into bit WIDTH-1, and mode 2'b10 moves the old `q[WIDTH-1]` into bit 0. In this build both serial inputs are ignored.
- R8: `q` changes only at a rising clock edge. Input changes made between edges leave `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| clr | input | 1 | Synchronous active-high clear, highest priority |
| mode | input | 2 | 00 hold, 01 shift toward LSB, 10 shift toward MSB, 11 parallel load |
| ser_in_r | input | 1 | Fill bit for bit WIDTH-1 during mode 01 |
| ser_in_l | input | 1 | Fill bit for bit 0 during mode 10 |
| par_in | input | WIDTH | Word copied in during mode 11 |
| q | output | WIDTH | Register contents |
| ser_out_r | output | 1 | Bit leaving on shifts toward LSB (q[0]) |
| ser_out_l | output | 1 | Bit leaving on shifts toward MSB (q[WIDTH-1]) |

## Verification
Every change to `q` is due exactly one rising edge after the inputs that cause it. The serial outputs are due in that same cycle, because they follow `q` without further registers. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, so each sample sees exactly one update. For R8, `q` is also sampled just before the edge, after inputs were changed mid-cycle, to confirm the old value is still present. A default 4-bit build and an 8-bit rotating build run side by side on shared controls. Each is compared with its own model.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic keep;     // current stage value
        logic from_hi;  // neighbour toward MSB (or fill bit)
        logic from_lo;  // neighbour toward LSB (or fill bit)
        logic ext;      // parallel word bit
    } stage_taps_t;

    function automatic logic pick_tap(shift_mode_e m, stage_taps_t t);
        logic r;
        case (m)
            MODE_HOLD: r = t.keep;
            MODE_SHR:  r = t.from_hi;
            MODE_SHL:  r = t.from_lo;
            default:   r = t.ext;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/univ_shreg_stage.sv
module univ_shreg_stage
    import univ_shreg_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  shift_mode_e mode,
    input  stage_taps_t taps,
    output logic        bit_q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= pick_tap(mode, taps);
        end
    end

endmodule

// File: rtl/univ_shreg_fill.sv
module univ_shreg_fill #(
    parameter bit ROTATE = 1'b0
) (
    input  logic ser_in_r,
    input  logic ser_in_l,
    input  logic lsb_now,
    input  logic msb_now,
    output logic fill_hi,
    output logic fill_lo
);

    generate
        if (ROTATE) begin : g_ring
            assign fill_hi = lsb_now;
            assign fill_lo = msb_now;
        end else begin : g_open
            assign fill_hi = ser_in_r;
            assign fill_lo = ser_in_l;
        end
    endgenerate

endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
    import univ_shreg_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit ROTATE = 1'b0
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             ser_in_r,
    input  logic             ser_in_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out_r,
    output logic             ser_out_l
);

    localparam int TOP = WIDTH - 1;

    shift_mode_e mode_e;
    logic        fill_hi;
    logic        fill_lo;

    assign mode_e = shift_mode_e'(mode);

    univ_shreg_fill #(.ROTATE(ROTATE)) u_fill (
        .ser_in_r (ser_in_r),
        .ser_in_l (ser_in_l),
        .lsb_now  (q[0]),
        .msb_now  (q[TOP]),
        .fill_hi  (fill_hi),
        .fill_lo  (fill_lo)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        stage_taps_t taps;
        logic hi_src;
        logic lo_src;

        if (i == TOP) begin : g_hi_end
            assign hi_src = fill_hi;
        end else begin : g_hi_mid
            assign hi_src = q[i+1];
        end

        if (i == 0) begin : g_lo_end
            assign lo_src = fill_lo;
        end else begin : g_lo_mid
            assign lo_src = q[i-1];
        end

        assign taps = '{keep: q[i], from_hi: hi_src, from_lo: lo_src, ext: par_in[i]};

        univ_shreg_stage u_stage (
            .clk   (clk),
            .clr   (clr),
            .mode  (mode_e),
            .taps  (taps),
            .bit_q (q[i])
        );
    end

    assign ser_out_r = q[0];
    assign ser_out_l = q[TOP];

endmodule

// File: rtl/univ_shreg_chk.sv
module univ_shreg_chk #(
    parameter int WIDTH  = 4,
    parameter bit ROTATE = 1'b0
) (
    input logic             clk,
    input logic             clr,
    input logic [1:0]       mode,
    input logic             ser_in_r,
    input logic             ser_in_l,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q
);

    logic enter_hi;
    logic enter_lo;
    assign enter_hi = ROTATE ? q[0] : ser_in_r;
    assign enter_lo = ROTATE ? q[WIDTH-1] : ser_in_l;

    a_r1_clear_zeroes: assert property (@(posedge clk)
        clr |=> (q == '0));

    a_r2_hold_keeps: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b00) |=> (q == $past(q)));

    a_r3_shift_right: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b01) |=> (q == {$past(enter_hi), $past(q[WIDTH-1:1])}));

    a_r4_shift_left: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b10) |=> (q == {$past(q[WIDTH-2:0]), $past(enter_lo)}));

    a_r5_load_word: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b11) |=> (q == $past(par_in)));

endmodule

bind univ_shreg univ_shreg_chk #(.WIDTH(WIDTH), .ROTATE(ROTATE)) u_chk (
    .clk      (clk),
    .clr      (clr),
    .mode     (mode),
    .ser_in_r (ser_in_r),
    .ser_in_l (ser_in_l),
    .par_in   (par_in),
    .q        (q)
);

// File: tb/univ_shreg_test.sv
`timescale 1ns/1ps
module univ_shreg_test;

    logic       clk = 1'b0;
    logic       clr;
    logic [1:0] mode;
    logic       ser_in_r;
    logic       ser_in_l;
    logic [3:0] par4;
    logic [7:0] par8;
    logic [3:0] q4;
    logic [7:0] q8;
    logic       sor4, sol4, sor8, sol8;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] exp4;
    logic [7:0] exp8;

    always #2 clk = ~clk;

    univ_shreg #(.WIDTH(4), .ROTATE(1'b0)) uut (
        .clk(clk), .clr(clr), .mode(mode), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
        .par_in(par4), .q(q4), .ser_out_r(sor4), .ser_out_l(sol4)
    );

    univ_shreg #(.WIDTH(8), .ROTATE(1'b1)) uut_rot (
        .clk(clk), .clr(clr), .mode(mode), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
        .par_in(par8), .q(q8), .ser_out_r(sor8), .ser_out_l(sol8)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // apply one cycle of stimulus, update the models, compare after the edge
    task automatic step(input logic c, input logic [1:0] m, input logic sr, input logic sl,
                        input logic [3:0] p4, input logic [7:0] p8, input string tag);
        @(negedge clk);
        clr = c; mode = m; ser_in_r = sr; ser_in_l = sl; par4 = p4; par8 = p8;
        if (c) begin
            exp4 = '0; exp8 = '0;
        end else begin
            case (m)
                2'b01: begin exp4 = {sr, exp4[3:1]}; exp8 = {exp8[0], exp8[7:1]}; end
                2'b10: begin exp4 = {exp4[2:0], sl}; exp8 = {exp8[6:0], exp8[7]}; end
                2'b11: begin exp4 = p4; exp8 = p8; end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check({tag, " q"}, {4'b0, q4}, {4'b0, exp4});
        check({tag, " rotating q (R7)"}, q8, exp8);
        check("R6 ser_out_r", {7'b0, sor4}, {7'b0, exp4[0]});
        check("R6 ser_out_l", {7'b0, sol4}, {7'b0, exp4[3]});
        check("R6 R7 rotating taps", {6'b0, sol8, sor8}, {6'b0, exp8[7], exp8[0]});
    endtask

    task automatic t_reset();
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'hF, 8'hFF, "R1 reset");
        step(1'b1, 2'b01, 1'b1, 1'b1, 4'hF, 8'hFF, "R1 reset again");
    endtask

    task automatic t_load();
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011, 8'b1001_0110, "R5 load a");
        step(1'b0, 2'b11, 1'b1, 1'b1, 4'b0110, 8'b1100_0001, "R5 load b");
        step(1'b0, 2'b11, 1'b0, 1'b1, 4'b1011, 8'b1001_0110, "R5 load c");
    endtask

    task automatic t_hold();
        step(1'b0, 2'b00, 1'b1, 1'b0, 4'b0100, 8'h3C, "R2 hold");
        step(1'b0, 2'b00, 1'b0, 1'b1, 4'b1111, 8'hFF, "R2 hold");
    endtask

    task automatic t_right();
        step(1'b0, 2'b01, 1'b0, 1'b1, 4'h0, 8'h00, "R3 right fill 0");
        step(1'b0, 2'b01, 1'b1, 1'b0, 4'h0, 8'h00, "R3 right fill 1");
        step(1'b0, 2'b01, 1'b1, 1'b0, 4'h0, 8'h00, "R3 right fill 1");
    endtask

    task automatic t_left();
        step(1'b0, 2'b10, 1'b0, 1'b1, 4'h0, 8'h00, "R4 left fill 1");
        step(1'b0, 2'b10, 1'b1, 1'b0, 4'h0, 8'h00, "R4 left fill 0");
        step(1'b0, 2'b10, 1'b0, 1'b1, 4'h0, 8'h00, "R4 left fill 1");
    endtask

    task automatic t_midcycle();
        logic [3:0] before4;
        logic [7:0] before8;
        @(negedge clk);
        before4 = q4; before8 = q8;
        mode = 2'b11; par4 = ~q4; par8 = ~q8; ser_in_r = ~ser_in_r;
        #1;
        check("R8 no change before edge", {4'b0, q4}, {4'b0, before4});
        check("R8 rotating no change before edge", q8, before8);
        step(1'b0, 2'b11, ser_in_r, ser_in_l, ~before4, ~before8, "R8 update at edge");
    endtask

    task automatic t_rotate_ring();
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0001, 8'b0000_0001, "R7 seed");
        for (int k = 0; k < 9; k++)
            step(1'b0, 2'b01, 1'b1, 1'b1, 4'h0, 8'h00, "R7 ring right");
        for (int k = 0; k < 3; k++)
            step(1'b0, 2'b10, 1'b0, 1'b0, 4'h0, 8'h00, "R7 ring left");
    endtask

    task automatic t_clear_override();
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111, 8'hFF, "R5 load ones");
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, 8'hFF, "R1 clear beats load");
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, 8'h81, "R5 load after clear");
        step(1'b1, 2'b01, 1'b1, 1'b1, 4'b1111, 8'hFF, "R1 clear beats shift");
    endtask

    initial begin
        clr = 1'b1; mode = 2'b00; ser_in_r = 1'b0; ser_in_l = 1'b0; par4 = '0; par8 = '0;
        exp4 = '0; exp8 = '0;
        t_reset();
        t_load();
        t_hold();
        t_right();
        t_left();
        t_midcycle();
        t_rotate_ring();
        t_clear_override();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule